// File: doc/BRIEF.md
# Dual Rate Bidirectional LED Shifter

Two 8-bit shift registers share one serial data bit and together drive a row of 16 indicator LEDs. Lane A always moves one position toward its least significant bit on every clock, with the new bit entering at the most significant end. Lane B runs either faster or slower than lane A, chosen by a rate select. It can move the same way as lane A or the opposite way, chosen by a direction input.

A circular mode turns both lanes into rotators. While rotating, a load-enable input decides on each clock whether the bit that falls off one end re-enters at the other end, or whether the serial bit enters in its place. Outside circular mode the serial bit always enters and the load-enable is ignored. Button conditioning and slow-clock generation are handled outside this block. Every output comes straight from a flip-flop.

Top module: `dual_rate_led_shifter`

## Requirements
- R1: A synchronous active-high `rst` sets both lanes to 00h and clears the lane B half-rate phase. After `rst` falls, the first clock edge with `b_half_rate`=1 holds lane B, and the second edge moves it.
- R2: Lane A moves one position toward bit 0 on every clock edge, and the fill bit enters at bit 7. For example, 98h with fill 0 becomes 4Ch.
- R3: With `b_left`=0, lane B moves toward bit 0 and the fill enters at bit 7. With `b_left`=1, lane B moves toward bit 7 and the fill enters at bit 0. For example, 98h with fill 0 moving left becomes 30h.
- R4: With `circ_mode`=0, the fill bit is always `ser_in`, and `load_en` has no effect on either lane.
- R5: With `circ_mode`=1 and `load_en`=0, the bit leaving a lane re-enters at the opposite end (rotation). For example, lane A 13h becomes 89h.
- R6: With `circ_mode`=1 and `load_en`=1, `ser_in` takes the place of the bit that leaves.
- R7: With `b_half_rate`=0, lane B moves two positions on every edge. Both vacated positions take the fill bit when that bit is `ser_in`.
- R8: With `b_half_rate`=0, `circ_mode`=1 and `load_en`=0, lane B rotates by two positions on each edge.
- R9: A phase bit toggles on every edge after reset. With `b_half_rate`=1, lane B moves one position only on edges where the phase was 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit shared by both lanes |
| load_en | input | 1 | In circular mode, 1 makes `ser_in` replace the wrapped bit |
| circ_mode | input | 1 | 1 = rotate, 0 = plain shift |
| b_half_rate | input | 1 | Lane B rate: 0 = two positions per clock, 1 = one position every other clock |
| b_left | input | 1 | Lane B direction: 0 = toward bit 0, 1 = toward bit 7 |
| lane_a | output | 8 | Lane A contents |
| lane_b | output | 8 | Lane B contents |

## Verification
A wrong half-rate phase shows up at the `lane_b` port on the very next edge. Lane B either moves when it should hold or holds when it should move, so the expected sequence slips by one position. A wrong fill choice, where the wrapped bit and the serial bit are swapped, changes the population count of a rotating lane within one edge. A lane with a wrong step count or direction breaks the one-clock neighbour relation between successive output values immediately. Since every output is registered, each fault appears exactly one clock after the edge that caused it.

// File: rtl/dual_shift_pkg.sv
`timescale 1ns/1ps
package dual_shift_pkg;
  // direction of travel of a lane
  typedef enum logic {
    MOVE_TO_LSB = 1'b0,
    MOVE_TO_MSB = 1'b1
  } move_dir_e;

  // lane B pacing
  typedef enum logic {
    PACE_DOUBLE = 1'b0,
    PACE_HALF   = 1'b1
  } pace_e;
endpackage

// File: rtl/shift_step.sv
`timescale 1ns/1ps
// One-position move of a vector, with choice of fill bit.
module shift_step
  import dual_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vin,
  input  move_dir_e        dir,
  input  logic             wrap,
  input  logic             ser,
  output logic [WIDTH-1:0] vout
);
  localparam int TOP = WIDTH - 1;

  logic leaving;
  logic fill;

  always_comb begin
    leaving = (dir == MOVE_TO_LSB) ? vin[0] : vin[TOP];
    fill    = wrap ? leaving : ser;
    if (dir == MOVE_TO_LSB)
      vout = {fill, vin[TOP:1]};
    else
      vout = {vin[TOP-1:0], fill};
  end
endmodule

// File: rtl/pace_phase.sv
`timescale 1ns/1ps
// Alternating phase bit used to pace the slow lane.
module pace_phase (
  input  logic clk,
  input  logic rst,
  output logic phase
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      armed <= 1'b1;
    end else begin
      phase <= ~phase;
    end
  end

  // R9: phase alternates on every edge outside reset
  a_r9_phase_toggles: assert property (@(posedge clk) disable iff (rst)
    armed |=> phase != $past(phase));
endmodule

// File: rtl/shift_lane.sv
`timescale 1ns/1ps
// A register lane that moves by 1 or MAX_STEPS positions per advance.
module shift_lane
  import dual_shift_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int MAX_STEPS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             multi,
  input  move_dir_e        dir,
  input  logic             wrap,
  input  logic             ser,
  output logic [WIDTH-1:0] q
);
  localparam int NSTAGE = MAX_STEPS + 1;

  logic [WIDTH-1:0] stage [NSTAGE];
  logic [WIDTH-1:0] nxt;
  logic             armed;

  assign stage[0] = q;

  for (genvar s = 0; s < MAX_STEPS; s++) begin : g_chain
    shift_step #(.WIDTH(WIDTH)) u_step (
      .vin  (stage[s]),
      .dir  (dir),
      .wrap (wrap),
      .ser  (ser),
      .vout (stage[s+1])
    );
  end

  always_comb begin
    if (!advance)
      nxt = q;
    else if (multi)
      nxt = stage[MAX_STEPS];
    else
      nxt = stage[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      armed <= 1'b1;
    end else begin
      q <= nxt;
    end
  end

  // R9: an idle lane keeps its contents
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    armed && !advance |=> $stable(q));

  // R5 and R8: rotation never creates or loses a set bit
  a_r5_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
    armed && advance && wrap |=> $countones(q) == $countones($past(q)));
endmodule

// File: rtl/dual_rate_led_shifter.sv
`timescale 1ns/1ps
module dual_rate_led_shifter
  import dual_shift_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int FAST_STEPS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             load_en,
  input  logic             circ_mode,
  input  logic             b_half_rate,
  input  logic             b_left,
  output logic [WIDTH-1:0] lane_a,
  output logic [WIDTH-1:0] lane_b
);
  localparam int TOP = WIDTH - 1;

  logic      wrap;
  logic      phase;
  pace_e     pace;
  move_dir_e dir_b;
  logic      adv_b;
  logic      multi_b;

  assign wrap    = circ_mode & ~load_en;
  assign pace    = pace_e'(b_half_rate);
  assign dir_b   = move_dir_e'(b_left);
  assign multi_b = (pace == PACE_DOUBLE);
  assign adv_b   = multi_b | phase;

  pace_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  shift_lane #(.WIDTH(WIDTH), .MAX_STEPS(1)) u_lane_a (
    .clk     (clk),
    .rst     (rst),
    .advance (1'b1),
    .multi   (1'b0),
    .dir     (MOVE_TO_LSB),
    .wrap    (wrap),
    .ser     (ser_in),
    .q       (lane_a)
  );

  shift_lane #(.WIDTH(WIDTH), .MAX_STEPS(FAST_STEPS)) u_lane_b (
    .clk     (clk),
    .rst     (rst),
    .advance (adv_b),
    .multi   (multi_b),
    .dir     (dir_b),
    .wrap    (wrap),
    .ser     (ser_in),
    .q       (lane_b)
  );

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> lane_a == '0 && lane_b == '0);

  a_r2_a_moves_down: assert property (@(posedge clk) disable iff (rst)
    armed |=> lane_a[TOP-1:0] == $past(lane_a[TOP:1]));

  a_r4_plain_takes_serial: assert property (@(posedge clk) disable iff (rst)
    armed && !circ_mode |=> lane_a[TOP] == $past(ser_in));

  a_r6_load_replaces_wrap: assert property (@(posedge clk) disable iff (rst)
    armed && circ_mode && load_en |=> lane_a[TOP] == $past(ser_in));

  a_r3_b_left_fast: assert property (@(posedge clk) disable iff (rst)
    armed && b_left && !b_half_rate |=> lane_b[TOP:2] == $past(lane_b[TOP-2:0]));
endmodule

// File: tb/sim_dual_rate_led_shifter.sv
`timescale 1ns/1ps
module sim_dual_rate_led_shifter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0, load_en = 1'b0, circ_mode = 1'b0;
  logic b_half_rate = 1'b0, b_left = 1'b0;
  logic [7:0] lane_a, lane_b;

  int nchecks = 0;
  int nerr = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_rate_led_shifter u0 (
    .clk(clk), .rst(rst), .ser_in(ser_in), .load_en(load_en),
    .circ_mode(circ_mode), .b_half_rate(b_half_rate), .b_left(b_left),
    .lane_a(lane_a), .lane_b(lane_b)
  );

  // {ser, load_en, circ, half_rate, left, expected A, expected B}
  localparam logic [20:0] VEC [0:13] = '{
    {5'b10000, 8'h80, 8'hC0},  // R2 R7
    {5'b00000, 8'h40, 8'h30},  // R2 R7
    {5'b10000, 8'hA0, 8'hCC},  // R2 R7
    {5'b10001, 8'hD0, 8'h33},  // R3 R7
    {5'b00101, 8'h68, 8'hCC},  // R5 R8
    {5'b00110, 8'h34, 8'h66},  // R5 R9 move
    {5'b00110, 8'h1A, 8'h66},  // R9 hold
    {5'b00110, 8'h0D, 8'h33},  // R9 move
    {5'b11111, 8'h86, 8'h33},  // R6 R9 hold
    {5'b01111, 8'h43, 8'h66},  // R6 R3 move left
    {5'b10011, 8'hA1, 8'h66},  // R4 hold
    {5'b11011, 8'hD0, 8'hCD},  // R4 load_en ignored
    {5'b11100, 8'hE8, 8'hF3},  // R6 R7
    {5'b10100, 8'h74, 8'hFC}   // R5 R8
  };

  string tag_a [0:13] = '{"R2","R2","R2","R2","R5","R5","R5","R5",
                          "R6","R6","R4","R4","R6","R5"};
  string tag_b [0:13] = '{"R7","R7","R7","R3","R8","R9","R9","R9",
                          "R9","R3","R9","R4","R7","R8"};

  task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    nchecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    check8("R1", "lane_a after reset", lane_a, 8'h00);
    check8("R1", "lane_b after reset", lane_b, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      {ser_in, load_en, circ_mode, b_half_rate, b_left} = VEC[i][20:16];
      tick();
      check8(tag_a[i], $sformatf("lane_a vec %0d", i), lane_a, VEC[i][15:8]);
      check8(tag_b[i], $sformatf("lane_b vec %0d", i), lane_b, VEC[i][7:0]);
    end

    // R1: reset in mid-run with serial 1 present still clears
    ser_in = 1'b1; circ_mode = 1'b0; load_en = 1'b0;
    b_half_rate = 1'b1; b_left = 1'b0;
    rst = 1'b1;
    tick();
    check8("R1", "lane_a mid-run reset", lane_a, 8'h00);
    check8("R1", "lane_b mid-run reset", lane_b, 8'h00);
    rst = 1'b0;
    // R1 R9: phase cleared, so first edge holds lane B
    tick();
    check8("R2", "lane_a first edge", lane_a, 8'h80);
    check8("R1", "lane_b holds on first edge", lane_b, 8'h00);
    tick();
    check8("R2", "lane_a second edge", lane_a, 8'hC0);
    check8("R9", "lane_b moves on second edge", lane_b, 8'h80);

    // R5: rotation of lane A carries bit 0 to bit 7
    ser_in = 1'b0; circ_mode = 1'b1; load_en = 1'b0;
    tick();
    check8("R5", "lane_a rotate", lane_a, 8'h60);
    check8("R9", "lane_b hold", lane_b, 8'h80);
    tick();
    check8("R5", "lane_a rotate again", lane_a, 8'h30);
    check8("R5", "lane_b rotate", lane_b, 8'h40);

    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule